// File: doc/BRIEF.md
# Scan-Testable Serial Stream Comparator

This block watches two single-bit serial streams and compares them bit by bit on every clock. It reports a registered per-cycle mismatch bit and a registered overflow flag. The overflow flag rises once the run of back-to-back mismatching bits exceeds a fixed limit. The run length is held in a small saturating counter.

Every storage element is a multiplexed-D scan cell: three counter bits, the mismatch bit and the overflow bit. The five cells are stitched into one serial chain. With the scan enable high, a tester can load any state through one serial input and read it back through one serial output. The shift does not disturb the functional logic. With the scan enable low, the block behaves exactly like a plain register implementation.

Top module: `stream_cmp_scan`

## Requirements
- R1: With scan_en low and rst_n high, the outp value after a clock edge equals line1 XOR line2 as sampled at that edge.
- R2: Reset is synchronous and active low. An edge with rst_n low clears all five state bits, so outp and overflow read 0. This holds even when scan_en is high at that edge.
- R3: The run counter (3 bits, state bits 2..0) increments on a functional edge where line1 differs from line2. It clears to 0 on a functional edge where they are equal.
- R4: The run counter saturates at 7. Further mismatches leave it at 7.
- R5: After a functional edge, overflow is 1 exactly when the updated run count is greater than 3. It first rises on the fourth consecutive mismatch.
- R6: On an edge with scan_en high and rst_n high, each cell takes the value of its scan source rather than its functional input. scan_in feeds bit 4, bit k+1 feeds bit k, and bit 0 drives scan_out.
- R7: The state word is fixed as bit 4 = overflow, bit 3 = outp, bits 2..0 = run count. scan_out presents bit 0 before any shift and original bit k after k shifts. Shifting in b0 first and b4 last leaves the word b4..b0, which is visible at once on outp and overflow.
- R8: A functional edge that follows a scan load updates from the loaded state. For example, a loaded count of 3 plus a mismatch gives count 4 with overflow 1, and a loaded count of 6 plus a mismatch gives 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low, wins over shifting |
| line1 | input | 1 | First serial stream |
| line2 | input | 1 | Second serial stream |
| scan_en | input | 1 | 1 = shift chain, 0 = functional capture |
| scan_in | input | 1 | Serial input to the chain head (state bit 4) |
| outp | output | 1 | Registered mismatch of the two streams |
| overflow | output | 1 | Registered long-mismatch-run flag |
| scan_out | output | 1 | Chain tail (state bit 0) |

## Verification
Every result is due one edge after its stimulus, because outp, overflow, the counter and each chain cell are single registers. The bench therefore drives inputs on the falling edge and samples one time unit after the next rising edge. The counter is read through the chain with a rotating five-edge dump that feeds scan_out back into scan_in, so the state is restored before the next functional step. Scan-loaded values are checked right after the fifth shift edge, and their functional follow-up one edge later.

// File: rtl/stream_cmp_pkg.sv
`timescale 1ns/1ps
package stream_cmp_pkg;

  typedef enum logic {
    CELL_CAPTURE = 1'b0,
    CELL_SHIFT   = 1'b1
  } cell_mode_e;

  function automatic cell_mode_e mode_of(input logic se);
    return se ? CELL_SHIFT : CELL_CAPTURE;
  endfunction

endpackage

// File: rtl/stream_cmp_cell.sv
`timescale 1ns/1ps
module stream_cmp_cell
  import stream_cmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic se,
  input  logic d,
  input  logic si,
  output logic q
);

  cell_mode_e mode_w;
  logic       pick_w;

  assign mode_w = mode_of(se);
  assign pick_w = (mode_w == CELL_SHIFT) ? si : d;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= pick_w;
  end

  // R6
  cell_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    se |=> (q == $past(si)));

  // R1
  cell_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !se |=> (q == $past(d)));

endmodule

// File: rtl/stream_cmp_next.sv
`timescale 1ns/1ps
module stream_cmp_next #(
  parameter int CNT_W = 3,
  parameter int LIMIT = 3,
  localparam int ST_W = CNT_W + 2
) (
  input  logic [ST_W-1:0] st,
  input  logic            line1,
  input  logic            line2,
  output logic [ST_W-1:0] st_nxt,
  output logic            miss_w
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] run_step(input logic [CNT_W-1:0] c,
                                                input logic miss);
    if (!miss)        return '0;
    if (c == CNT_TOP) return c;
    return c + CNT_ONE;
  endfunction

  function automatic logic above_limit(input logic [CNT_W-1:0] c);
    return int'({1'b0, c}) > LIMIT;
  endfunction

  logic [CNT_W-1:0] cnt_now;
  logic [CNT_W-1:0] cnt_nxt;

  assign miss_w  = line1 ^ line2;
  assign cnt_now = st[CNT_W-1:0];
  assign cnt_nxt = run_step(cnt_now, miss_w);

  always_comb begin
    st_nxt              = '0;
    st_nxt[CNT_W-1:0]   = cnt_nxt;
    st_nxt[ST_W-2]      = miss_w;
    st_nxt[ST_W-1]      = above_limit(cnt_nxt);
  end

endmodule

// File: rtl/stream_cmp_chain.sv
`timescale 1ns/1ps
module stream_cmp_chain #(
  parameter int LEN = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           se,
  input  logic [LEN-1:0] d,
  input  logic           chain_in,
  output logic [LEN-1:0] q,
  output logic           chain_out
);

  logic [LEN-1:0] src_w;

  genvar gi;
  generate
    for (gi = 0; gi < LEN; gi++) begin : g_cell
      if (gi == LEN - 1) begin : g_head
        assign src_w[gi] = chain_in;
      end else begin : g_link
        assign src_w[gi] = q[gi+1];
      end
      stream_cmp_cell u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .se   (se),
        .d    (d[gi]),
        .si   (src_w[gi]),
        .q    (q[gi])
      );
    end
  endgenerate

  assign chain_out = q[0];

endmodule

// File: rtl/stream_cmp_scan.sv
`timescale 1ns/1ps
module stream_cmp_scan #(
  parameter int CNT_W = 3,
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line1,
  input  logic line2,
  input  logic scan_en,
  input  logic scan_in,
  output logic outp,
  output logic overflow,
  output logic scan_out
);

  localparam int ST_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [ST_W-1:0]  st_w;
  logic [ST_W-1:0]  st_nxt_w;
  logic             miss_w;
  logic [CNT_W-1:0] cnt_w;

  stream_cmp_next #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_next (
    .st    (st_w),
    .line1 (line1),
    .line2 (line2),
    .st_nxt(st_nxt_w),
    .miss_w(miss_w)
  );

  stream_cmp_chain #(.LEN(ST_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .se       (scan_en),
    .d        (st_nxt_w),
    .chain_in (scan_in),
    .q        (st_w),
    .chain_out(scan_out)
  );

  assign cnt_w    = st_w[CNT_W-1:0];
  assign outp     = st_w[ST_W-2];
  assign overflow = st_w[ST_W-1];

  // R2
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (st_w == '0));

  // R1
  outp_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (outp == $past(line1 ^ line2)));

  // R3
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !miss_w) |=> (cnt_w == '0 && !overflow));

  // R3
  run_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && miss_w && cnt_w != CNT_TOP) |=> (cnt_w == $past(cnt_w) + CNT_ONE));

  // R4
  run_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && miss_w && cnt_w == CNT_TOP) |=> (cnt_w == CNT_TOP));

  // R5
  ovf_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (overflow == (int'({1'b0, cnt_w}) > LIMIT)));

  // R7
  tail_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (scan_out == $past(st_w[1])));

endmodule

// File: tb/tb_stream_cmp_scan.sv
`timescale 1ns/1ps
module tb_stream_cmp_scan;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line1 = 1'b0, line2 = 1'b0, scan_en = 1'b0, scan_in = 1'b0;
  logic outp, overflow, scan_out;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  stream_cmp_scan dut (
    .clk(clk), .rst_n(rst_n), .line1(line1), .line2(line2),
    .scan_en(scan_en), .scan_in(scan_in),
    .outp(outp), .overflow(overflow), .scan_out(scan_out)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic a, input logic b,
                      input logic se, input logic si);
    @(negedge clk);
    rst_n = r; line1 = a; line2 = b; scan_en = se; scan_in = si;
    @(posedge clk);
    #1;
  endtask

  // rotating dump: reads bit k before shift k, restores state after 5 shifts
  task automatic dump(output logic [4:0] v);
    for (int k = 0; k < 5; k++) begin
      v[k] = scan_out;
      step(1'b1, 1'b0, 1'b0, 1'b1, scan_out);
    end
  endtask

  task automatic load(input logic [4:0] v);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b0, 1'b1, v[k]);
  endtask

  task automatic t_reset();
    logic [4:0] v;
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 reset outputs", {3'b0, outp, overflow}, 5'b0);
    dump(v);
    check("R2 reset state", v, 5'b0);
  endtask

  task automatic t_xor();
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0); check("R1 xor 00", {4'b0, outp}, 5'd0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0); check("R1 xor 10", {4'b0, outp}, 5'd1);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0); check("R1 xor 11", {4'b0, outp}, 5'd0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0); check("R1 xor 01", {4'b0, outp}, 5'd1);
  endtask

  task automatic t_run();
    logic [4:0] v;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 1; i <= 4; i++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R5 overflow on run", {4'b0, overflow}, (i >= 4) ? 5'd1 : 5'd0);
    end
    dump(v);
    check("R3 count four", v, 5'b11100);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    dump(v);
    check("R4 saturate", v, 5'b11111);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    dump(v);
    check("R3 match clears", v, 5'b00000);
  endtask

  task automatic t_scan();
    logic [4:0] v;
    load(5'b10110);
    check("R7 loaded outputs", {3'b0, outp, overflow}, 5'b00001);
    check("R7 tail bit0", {4'b0, scan_out}, 5'd0);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R6 one shift", {4'b0, scan_out}, 5'd1);
    load(5'b10110);
    dump(v);
    check("R7 dump order", v, 5'b10110);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    dump(v);
    check("R8 loaded 6 then miss", v, 5'b11111);
    load(5'b00011);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 loaded 3 then miss", {3'b0, outp, overflow}, 5'b00011);
    dump(v);
    check("R8 count four", v, 5'b11100);
  endtask

  task automatic t_rst_prio();
    logic [4:0] v;
    load(5'b11011);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R2 reset beats shift", {3'b0, outp, overflow}, 5'b0);
    dump(v);
    check("R2 reset beats shift state", v, 5'b0);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_xor();
    t_run();
    t_scan();
    t_rst_prio();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule